// File: doc/BRIEF.md
# Receive Data Port Framer

The framer sits behind a demodulator and controls the serial receive output. The demodulator supplies four things: a pulse when acquisition completes, a pulse when the start of the header is found, a tracking-good level, and a stream of demodulated bits, each marked by a one-cycle strobe.

Once acquisition completes, the framer starts a receive clock. This clock is one pulse per demodulated bit. The framer then collects a header of `HDR_W` bits followed by a 16-bit CRC and checks the whole header with the CCITT CRC-16. If the check passes, or if the configuration tells the framer to ignore CRC errors, it raises a data-ready envelope. It then shifts the payload bits out serially, in arrival order, so the first received bit is the least significant.

A down-counter loaded from the header length field closes the envelope after the last payload bit. Two events close it early: loss of tracking, or removal of the receive enable. The polarity of the receive clock and the polarity of the envelope can each be set by configuration.

The controller has six states:
- IDLE: waits for acquisition.
- SYNC: the clock runs while the framer waits for the header start.
- HDR: the framer collects the header and CRC bits.
- CHECK: one cycle in which the CRC result is judged.
- DATA: the envelope is active and the payload is output.
- TAIL: one cycle that holds the envelope over the last payload bit.

The transitions are:
- IDLE→SYNC on acquisition done.
- SYNC→HDR on header start.
- HDR→CHECK on the last CRC bit.
- CHECK→DATA when the header passes and the length is nonzero; CHECK→IDLE otherwise.
- DATA→TAIL on the last counted bit.
- TAIL→IDLE unconditionally.
- Any state goes to IDLE when the enable is low. SYNC, HDR and DATA also go to IDLE on tracking loss.

Top module: `rx_framer`

## Requirements
- R1: After reset the envelope output sits at its inactive level and the receive clock output sits at its inactive level. The inactive level is the value of the matching polarity bit.
- R2: After acquisition done, the receive clock pulses once per demodulated bit. The envelope stays inactive through preamble synchronization and the whole header. It becomes active only after the header check has completed.
- R3: The header is checked with CRC-16, polynomial x^16+x^12+x^5+1, preset all ones. The CRC is sent ones-complemented, most significant bit first. A header with a correct CRC asserts the envelope.
- R4: With `cfg_crc_ign`=0, a CRC failure keeps the envelope inactive and returns the framer to wait for the next acquisition. A following good frame is then delivered normally.
- R5: With `cfg_crc_ign`=1, a header with a bad CRC still asserts the envelope and outputs the full payload.
- R6: The length field is header bits [LEN_LSB +: LEN_W], sent least significant bit first. The envelope spans exactly that many receive clock pulses. `rx_dat_o` carries the payload in arrival order, so the first received bit is the LSB.
- R7: When tracking (`trk_ok`) goes low during the payload, the envelope ends in the next cycle and no further bits are output.
- R8: When `rx_en` goes low, the envelope ends in the next cycle. While `rx_en` is low, acquisition done is ignored and the receive clock stays inactive.
- R9: `cfg_clk_inv`=1 inverts the receive clock output and `cfg_rdy_inv`=1 inverts the envelope output. Framing is unchanged.
- R10: If tracking is lost in the same cycle as the final payload bit, the abort wins: that bit gets no clock pulse.
- R11: A header with a length field of zero never asserts the envelope.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Framer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receive enable; low holds standby |
| acq_done | input | 1 | Pulse: acquisition has completed |
| sfd_hit | input | 1 | Pulse: start of header found |
| trk_ok | input | 1 | High while tracking is held |
| bit_vld | input | 1 | Strobe marking a demodulated bit |
| bit_in | input | 1 | Demodulated bit value |
| cfg_clk_inv | input | 1 | Receive clock polarity: 1 = active low |
| cfg_rdy_inv | input | 1 | Envelope polarity: 1 = active low |
| cfg_crc_ign | input | 1 | 1 = ignore header CRC errors |
| rx_clk_o | output | 1 | Receive clock pulse, one per bit |
| rx_dat_o | output | 1 | Serial payload data |
| rdy_o | output | 1 | Data-ready envelope |

## Verification
The last payload bit, which would normally move DATA to TAIL, can arrive in the same cycle as a tracking loss. The bench provokes this by dropping `trk_ok` while it strobes the final bit of a three-bit frame. The judgement is made at the ports: exactly two clocked bits must have been captured under the envelope, and the envelope must be inactive afterwards. A second overlap is a bad CRC with the ignore bit set, which must still produce the full payload.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SYNC,
        ST_HDR,
        ST_CHECK,
        ST_DATA,
        ST_TAIL
    } rxf_state_e;

    localparam int          CRC_W       = 16;
    localparam logic [15:0] CRC_POLY    = 16'h1021;
    localparam logic [15:0] CRC_SEED    = 16'hFFFF;
    localparam logic [15:0] CRC_RESIDUE = 16'h1D0F;
endpackage

// File: rtl/rxf_crc16.sv
module rxf_crc16
    import rxf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic             din,
    output logic [CRC_W-1:0] crc_q
);
    logic fb;

    assign fb = crc_q[CRC_W-1] ^ din;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= CRC_SEED;
        end else if (clr) begin
            crc_q <= CRC_SEED;
        end else if (en) begin
            crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
    end
endmodule

// File: rtl/rxf_hdr_sreg.sv
module rxf_hdr_sreg #(
    parameter int HDR_W   = 32,
    parameter int LEN_LSB = 16,
    parameter int LEN_W   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             din,
    output logic [LEN_W-1:0] len_field
);
    localparam int KEEP_W = HDR_W - LEN_LSB;

    logic [KEEP_W-1:0] sreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
        end else if (en) begin
            sreg <= {din, sreg[KEEP_W-1:1]};
        end
    end

    assign len_field = sreg[LEN_W-1:0];
endmodule

// File: rtl/rxf_downcnt.sv
module rxf_downcnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - 1'b1;
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (cnt != '0)); // R6
endmodule

// File: rtl/rx_framer.sv
module rx_framer
    import rxf_pkg::*;
#(
    parameter int HDR_W   = 32,
    parameter int LEN_LSB = 16,
    parameter int LEN_W   = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_en,
    input  logic acq_done,
    input  logic sfd_hit,
    input  logic trk_ok,
    input  logic bit_vld,
    input  logic bit_in,
    input  logic cfg_clk_inv,
    input  logic cfg_rdy_inv,
    input  logic cfg_crc_ign,
    output logic rx_clk_o,
    output logic rx_dat_o,
    output logic rdy_o
);
    localparam int               HTOT    = HDR_W + CRC_W;
    localparam int               HCNT_W  = $clog2(HTOT + 1);
    localparam logic [HCNT_W-1:0] HCNT_LD = HCNT_W'(HTOT);
    localparam logic [HCNT_W-1:0] CRC_CNT = HCNT_W'(CRC_W);

    rxf_state_e        state, state_nx;
    logic              live;
    logic              hdr_bit, pay_bit;
    logic              crc_ok, hdr_pass;
    logic [CRC_W-1:0]  crc_q;
    logic [LEN_W-1:0]  len_field, pcnt;
    logic [HCNT_W-1:0] hcnt;
    logic              pulse_q, dat_q;
    logic              rdy_act;

    assign live    = rx_en && trk_ok;
    assign hdr_bit = (state == ST_HDR)  && bit_vld && live;
    assign pay_bit = (state == ST_DATA) && bit_vld && live;
    assign crc_ok  = (crc_q == CRC_RESIDUE);
    assign hdr_pass = crc_ok || cfg_crc_ign;

    rxf_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state == ST_SYNC),
        .en    (hdr_bit),
        .din   (bit_in),
        .crc_q (crc_q)
    );

    rxf_hdr_sreg #(
        .HDR_W   (HDR_W),
        .LEN_LSB (LEN_LSB),
        .LEN_W   (LEN_W)
    ) u_sreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (hdr_bit && (hcnt > CRC_CNT)),
        .din       (bit_in),
        .len_field (len_field)
    );

    rxf_downcnt #(.W(HCNT_W)) u_hcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     ((state == ST_SYNC) && sfd_hit),
        .load_val (HCNT_LD),
        .dec      (hdr_bit),
        .cnt      (hcnt)
    );

    rxf_downcnt #(.W(LEN_W)) u_pcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state == ST_CHECK),
        .load_val (len_field),
        .dec      (pay_bit),
        .cnt      (pcnt)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        if (!rx_en) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  if (acq_done) state_nx = ST_SYNC;
                ST_SYNC: begin
                    if (!trk_ok)      state_nx = ST_IDLE;
                    else if (sfd_hit) state_nx = ST_HDR;
                end
                ST_HDR: begin
                    if (!trk_ok)                        state_nx = ST_IDLE;
                    else if (bit_vld && hcnt == HCNT_W'(1)) state_nx = ST_CHECK;
                end
                ST_CHECK: begin
                    if (hdr_pass && len_field != '0) state_nx = ST_DATA;
                    else                             state_nx = ST_IDLE;
                end
                ST_DATA: begin
                    if (!trk_ok)                           state_nx = ST_IDLE;
                    else if (bit_vld && pcnt == LEN_W'(1)) state_nx = ST_TAIL;
                end
                ST_TAIL:  state_nx = ST_IDLE;
                default:  state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
            dat_q   <= 1'b0;
        end else begin
            pulse_q <= bit_vld && live && (state != ST_IDLE);
            if (state == ST_IDLE)
                dat_q <= 1'b0;
            else if (pay_bit)
                dat_q <= bit_in;
        end
    end

    // output decode
    always_comb begin
        rdy_act  = (state == ST_DATA) || (state == ST_TAIL);
        rdy_o    = rdy_act ^ cfg_rdy_inv;
        rx_clk_o = pulse_q ^ cfg_clk_inv;
        rx_dat_o = dat_q;
    end

    AST_RDY_AFTER_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_act) |-> ($past(state) == ST_CHECK)); // R2
    AST_CLK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_q) |-> ($past(state) != ST_IDLE)); // R2
    AST_BAD_CRC_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && !crc_ok && !cfg_crc_ign) |=> (state == ST_IDLE)); // R4
    AST_TRK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && !trk_ok) |=> (state == ST_IDLE)); // R7
    AST_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_en |=> (state == ST_IDLE)); // R8
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CHECK && len_field == '0) |=> (state == ST_IDLE)); // R11
endmodule

// File: tb/sim_rx_framer.sv
`timescale 1ns/1ps
module sim_rx_framer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rx_en = 1'b0, acq_done = 1'b0, sfd_hit = 1'b0, trk_ok = 1'b1;
    logic bit_vld = 1'b0, bit_in = 1'b0;
    logic cfg_clk_inv = 1'b0, cfg_rdy_inv = 1'b0, cfg_crc_ign = 1'b0;
    logic rx_clk_o, rx_dat_o, rdy_o;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    // monitor state
    logic [63:0] cap_val;
    int  ncap;
    bit  rdy_seen, early, ck_seen, ck_hdr, hdr_phase;

    always #2.5 clk = ~clk;

    rx_framer u0 (
        .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .acq_done(acq_done),
        .sfd_hit(sfd_hit), .trk_ok(trk_ok), .bit_vld(bit_vld), .bit_in(bit_in),
        .cfg_clk_inv(cfg_clk_inv), .cfg_rdy_inv(cfg_rdy_inv),
        .cfg_crc_ign(cfg_crc_ign), .rx_clk_o(rx_clk_o), .rx_dat_o(rx_dat_o),
        .rdy_o(rdy_o)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if ((rdy_o ^ cfg_rdy_inv) && (rx_clk_o ^ cfg_clk_inv)) begin
                if (ncap < 64) cap_val[ncap] = rx_dat_o;
                ncap = ncap + 1;
            end
            if (rdy_o ^ cfg_rdy_inv) begin
                rdy_seen = 1'b1;
                if (hdr_phase) early = 1'b1;
            end
            if (rx_clk_o ^ cfg_clk_inv) begin
                ck_seen = 1'b1;
                if (hdr_phase) ck_hdr = 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clr_mon();
        cap_val = '0; ncap = 0; rdy_seen = 0; early = 0; ck_seen = 0; ck_hdr = 0;
    endtask

    function automatic logic [15:0] crc_of(input logic [31:0] h);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < 32; i++) begin
            logic fb = c[15] ^ h[i];
            c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
        end
        return c;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    // entry and exit: 1 ns after a rising edge
    task automatic send_bit(input logic b, input bit kill);
        bit_in = b; bit_vld = 1'b1;
        if (kill) trk_ok = 1'b0;
        @(posedge clk); #1;
        bit_vld = 1'b0; trk_ok = 1'b1;
        @(posedge clk); #1;
    endtask

    // kind: 0 none, 1 tracking loss after stop_at bits, 2 enable drop after
    // stop_at bits, 3 tracking loss together with bit stop_at
    task automatic run_frame(input int len, input logic [63:0] pay, input bit bad,
                             input int stop_at, input int kind);
        logic [31:0] hdr;
        logic [15:0] tx;
        clr_mon();
        hdr = {len[15:0], 16'hA5C3};
        tx  = ~crc_of(hdr);
        if (bad) tx[3] = ~tx[3];
        acq_done = 1'b1; @(posedge clk); #1; acq_done = 1'b0;
        hdr_phase = 1'b1;
        idle(2);
        sfd_hit = 1'b1; @(posedge clk); #1; sfd_hit = 1'b0;
        for (int i = 0; i < 32; i++) begin
            bit_in = hdr[i]; bit_vld = 1'b1; @(posedge clk); #1; bit_vld = 1'b0;
            if (i == 31) hdr_phase = 1'b0;
            @(posedge clk); #1;
        end
        for (int j = 0; j < 16; j++) begin
            bit_in = tx[15-j]; bit_vld = 1'b1; @(posedge clk); #1; bit_vld = 1'b0;
            if (j == 15) hdr_phase = 1'b0;
            @(posedge clk); #1;
        end
        for (int k = 0; k < len; k++) begin
            if ((kind == 1 || kind == 2) && k == stop_at) begin
                if (kind == 1) begin
                    trk_ok = 1'b0; @(posedge clk); #1; trk_ok = 1'b1;
                end else begin
                    rx_en = 1'b0; @(posedge clk); #1;
                end
                break;
            end
            send_bit(pay[k], (kind == 3) && (k == stop_at));
            if (kind == 3 && k == stop_at) break;
        end
        idle(4);
    endtask

    task automatic t_reset();
        chk(rdy_o == 1'b0, "R1 envelope idle", rdy_o, 0);
        chk(rx_clk_o == 1'b0, "R1 clock idle", rx_clk_o, 0);
    endtask

    task automatic t_good();
        run_frame(5, 64'h16, 1'b0, 0, 0);
        chk(ck_hdr == 1'b1, "R2 clock before envelope", ck_hdr, 1);
        chk(early == 1'b0, "R2 envelope quiet in header", early, 0);
        chk(rdy_seen == 1'b1, "R3 good crc envelope", rdy_seen, 1);
        chk(ncap == 5, "R6 bit count", ncap, 5);
        chk(cap_val == 64'h16, "R6 bit order", cap_val, 64'h16);
        chk(rdy_o == 1'b0, "R6 envelope closed", rdy_o, 0);
    endtask

    task automatic t_bad_crc();
        cfg_crc_ign = 1'b0;
        run_frame(6, 64'h2D, 1'b1, 0, 0);
        chk(rdy_seen == 1'b0, "R4 bad crc no envelope", rdy_seen, 0);
        run_frame(6, 64'h2D, 1'b0, 0, 0);
        chk(ncap == 6 && cap_val == 64'h2D, "R4 recovery frame", cap_val, 64'h2D);
    endtask

    task automatic t_ignore();
        cfg_crc_ign = 1'b1;
        run_frame(7, 64'h5B, 1'b1, 0, 0);
        chk(ncap == 7, "R5 ignored crc count", ncap, 7);
        chk(cap_val == 64'h5B, "R5 ignored crc data", cap_val, 64'h5B);
        cfg_crc_ign = 1'b0;
    endtask

    task automatic t_trk_abort();
        run_frame(8, 64'hFF, 1'b0, 3, 1);
        chk(ncap == 3, "R7 bits before loss", ncap, 3);
        chk(rdy_o == 1'b0, "R7 envelope ended", rdy_o, 0);
    endtask

    task automatic t_en_abort();
        run_frame(8, 64'hAA, 1'b0, 2, 2);
        chk(ncap == 2, "R8 bits before disable", ncap, 2);
        clr_mon();
        acq_done = 1'b1; @(posedge clk); #1; acq_done = 1'b0;
        sfd_hit = 1'b1; @(posedge clk); #1; sfd_hit = 1'b0;
        for (int i = 0; i < 6; i++) send_bit(1'b1, 1'b0);
        chk(ck_seen == 1'b0, "R8 standby clock quiet", ck_seen, 0);
        chk(rdy_seen == 1'b0, "R8 standby envelope quiet", rdy_seen, 0);
        rx_en = 1'b1; idle(2);
    endtask

    task automatic t_pol();
        cfg_clk_inv = 1'b1; cfg_rdy_inv = 1'b1; idle(1);
        chk(rdy_o == 1'b1, "R9 inverted envelope idle", rdy_o, 1);
        chk(rx_clk_o == 1'b1, "R9 inverted clock idle", rx_clk_o, 1);
        run_frame(4, 64'h9, 1'b0, 0, 0);
        chk(ncap == 4 && cap_val == 64'h9, "R9 inverted framing", cap_val, 64'h9);
        cfg_clk_inv = 1'b0; cfg_rdy_inv = 1'b0; idle(1);
    endtask

    task automatic t_same();
        run_frame(3, 64'h7, 1'b0, 2, 3);
        chk(ncap == 2, "R10 abort beats last bit", ncap, 2);
        chk(rdy_o == 1'b0, "R10 envelope ended", rdy_o, 0);
    endtask

    task automatic t_zero();
        run_frame(0, 64'h0, 1'b0, 0, 0);
        chk(rdy_seen == 1'b0, "R11 zero length", rdy_seen, 0);
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        nchk++; nerr++;
        $display("FAIL watchdog actual=1 expected=0");
        report();
    end

    initial begin
        clr_mon(); hdr_phase = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        rx_en = 1'b1; idle(1);
        t_good();
        t_bad_crc();
        t_ignore();
        t_trk_abort();
        t_en_abort();
        t_pol();
        t_same();
        t_zero();
        report();
    end
endmodule